// File: doc/BRIEF.md
# External Interrupt Request Flag

This block turns an active-low external interrupt pin into a single interrupt request flag. A mode input chosen by software selects one of two behaviours. In falling-edge mode the block latches a request when the pin goes from high to low. The request stays set until the interrupt is vectored, which the controller signals with an acknowledge strobe, or until software writes the flag. In low-level mode the request is transparent: it is active for as long as the synchronized pin is low. Acknowledge and software writes have no effect on it in this mode.

The raw pin first passes a two-flop synchronizer. A falling edge is a synchronized sample of 0 that follows a sample of 1. Software reads the flag on `req_o`, which is also the request sent to the interrupt controller. Priority, masking and vector generation happen elsewhere. The asynchronous reset is released on a clock edge inside the block.

Top module: `xint_req`

## Requirements
- R1: During reset and right after it, with the pin held high, `req_o` is 0.
- R2: In low-level mode (`trig_edge` = 0), `req_o` after a clock edge equals the inverse of the pin value sampled one edge earlier. This gives a two-edge latency through the synchronizer.
- R3: In falling-edge mode (`trig_edge` = 1), a pin that was sampled high and then low sets `req_o` on the third clock edge after the first low sample.
- R4: In falling-edge mode, a set flag stays set while the pin stays low or returns high, and a rising edge on the pin never sets the flag.
- R5: In falling-edge mode, `vec_ack` = 1 at a clock edge clears the flag when no new falling edge and no software write arrive at the same edge.
- R6: In low-level mode, `vec_ack` has no effect; `req_o` keeps following the pin.
- R7: In falling-edge mode, a falling edge detected at the same edge as `vec_ack` leaves the flag set.
- R8: In falling-edge mode, `flag_we` = 1 loads `flag_wdata` into the flag. A write takes priority over `vec_ack`, and a detected falling edge takes priority over a write of 0.
- R9: In low-level mode, software writes have no effect; `req_o` keeps following the pin.
- R10: Changing from low-level to falling-edge mode while the pin is low gives `req_o` = 0. The flag then sets only after a new high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_pin_n | input | 1 | Raw external interrupt pin, active low, asynchronous |
| trig_edge | input | 1 | 1 = falling-edge triggered, 0 = low-level triggered |
| vec_ack | input | 1 | Strobe: interrupt has been vectored |
| flag_we | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag |
| req_o | output | 1 | Interrupt request and flag read-back |

## Verification
The hardest case to reach is an acknowledge that arrives in exactly the cycle in which the synchronized falling edge is detected. The window is one cycle wide and sits two edges after the pin changes. The stimulus drops the pin and then raises `vec_ack` on the third step after that, so the two events meet at one edge. A second hard case is the mode change from low level to falling edge while the pin is held low, where a wrong design turns a stale level into a request. The stimulus holds the pin low across that change and then checks that no request appears until the pin goes high and low again.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned MIN_STAGES = 2;
endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync #(
  parameter int unsigned STAGES = xint_pkg::MIN_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_pin_sync.sv
module xint_pin_sync #(
  parameter int unsigned STAGES = xint_pkg::MIN_STAGES,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{IDLE}};
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];

  // R2: the synchronized output lags the previous stage by one edge
  assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_o == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/xint_fall_det.sv
module xint_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~lvl_i;

  // R4: a fall is only reported for a low sample that followed a high one
  assert_fall_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!lvl_i && $past(lvl_i)));
endmodule

// File: rtl/xint_flag.sv
module xint_flag
  import xint_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e mode_i,
  input  logic  fall_i,
  input  logic  ack_i,
  input  logic  we_i,
  input  logic  wdata_i,
  output logic  flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_d = flag_q;
    if (mode_i == TRIG_LEVEL) flag_d = 1'b0;
    else if (fall_i)          flag_d = 1'b1;
    else if (we_i)            flag_d = wdata_i;
    else if (ack_i)           flag_d = 1'b0;
    flag_en = (flag_d != flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R3 and R7: a detected fall in edge mode always leaves the flag set
  assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRIG_FALL && fall_i) |=> flag_q);

  // R5: a lone acknowledge clears the flag
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRIG_FALL && ack_i && !fall_i && !we_i) |=> !flag_q);

  // R8: a software write without a competing fall loads the data
  assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRIG_FALL && we_i && !fall_i) |=> (flag_q == $past(wdata_i)));

  // R10: level mode leaves no latched state behind
  assert_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRIG_LEVEL) |=> !flag_q);
endmodule

// File: rtl/xint_req.sv
module xint_req
  import xint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_pin_n,
  input  logic trig_edge,
  input  logic vec_ack,
  input  logic flag_we,
  input  logic flag_wdata,
  output logic req_o
);
  logic  rst_int_n;
  logic  pin_sync;
  logic  fall;
  logic  flag;
  trig_e mode;

  assign mode = trig_e'(trig_edge);

  xint_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  xint_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (int_pin_n),
    .sync_o (pin_sync)
  );

  xint_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (pin_sync),
    .fall_o (fall)
  );

  xint_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode_i  (mode),
    .fall_i  (fall),
    .ack_i   (vec_ack),
    .we_i    (flag_we),
    .wdata_i (flag_wdata),
    .flag_o  (flag)
  );

  assign req_o = (mode == TRIG_FALL) ? flag : ~pin_sync;

  // R1: no request while the internal reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_int_n) |-> !flag);

  // R6 and R9: in level mode a stable synchronized pin keeps the request stable
  assert_level_stable_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == TRIG_LEVEL && $past(mode == TRIG_LEVEL) && $stable(pin_sync)) |-> $stable(req_o));
endmodule

// File: tb/tb_xint_req.sv
`timescale 1ns/1ps
module tb_xint_req;
  logic clk = 1'b0;
  logic rst_n;
  logic int_pin_n, trig_edge, vec_ack, flag_we, flag_wdata;
  logic req_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
  logic mflag = 1'b0;

  always #4 clk = ~clk;

  xint_req dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_pin_n  (int_pin_n),
    .trig_edge  (trig_edge),
    .vec_ack    (vec_ack),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .req_o      (req_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the value expected after the edge
  task automatic step(input logic p, input logic m, input logic a,
                      input logic w, input logic wd, input string tag);
    item_t it;
    logic fall;
    @(negedge clk);
    int_pin_n = p; trig_edge = m; vec_ack = a; flag_we = w; flag_wdata = wd;
    fall = h3 & ~h2;
    if (!m)        mflag = 1'b0;
    else if (fall) mflag = 1'b1;
    else if (w)    mflag = wd;
    else if (a)    mflag = 1'b0;
    it.exp = m ? mflag : ~h1;
    it.tag = tag;
    h3 = h2; h2 = h1; h1 = p;
    sb.push_back(it);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(req_o, it.exp, it.tag);
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    int_pin_n = 1'b1; trig_edge = 1'b0; vec_ack = 1'b0; flag_we = 1'b0; flag_wdata = 1'b0;
    repeat (3) @(negedge clk);
    check(req_o, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R1");

    // R2: level follow, including a one-cycle pulse
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R2");

    // R6: acknowledge in level mode with the pin low and then high
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R6");

    // R9: writes in level mode
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 1, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R9");

    // R3: edge mode, falling edge sets
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, "R3");
    // R4: flag holds while the pin goes high
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, "R4");
    // R5: acknowledge clears
    step(1, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 2; i++) step(1, 1, 0, 0, 0, "R5");
    // fall again, clear while low, then a rising edge must not set (R4)
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R4");

    // R7: acknowledge lands at the same edge as the detected fall
    step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R5");

    // R8: software writes, write over acknowledge, fall over a write of 0
    step(1, 1, 0, 1, 1, "R8");
    step(1, 1, 0, 0, 0, "R8");
    step(1, 1, 0, 1, 0, "R8");
    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 0, 0, 0, "R8");
    step(1, 1, 1, 1, 0, "R8");
    step(0, 1, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, "R8");
    step(0, 1, 0, 1, 0, "R8");
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, "R8");

    // R10: level mode with pin low, then switch to edge mode
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule